// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns eight synchronized input pin levels into sticky per-pin interrupt status and one combined interrupt request. Each pin has its own settings for direction, detection kind (level or edge), edge choice, polarity and enable. The register interface stores these settings and passes them in as plain vectors. It also sends a one-cycle clear strobe that carries a clear pattern.

Each pin has a two-state machine. `PS_IDLE` means no event has been recorded. `PS_PEND` means an event is latched. The transition `IDLE->PEND` (arm) happens on any clock edge where the pin's trigger condition holds. The transition `PEND->IDLE` (release) happens only when the clear strobe carries a 1 for that pin and the trigger condition is false in the same cycle. Otherwise the machine holds.

The trigger condition comes from the live pin level and a copy of that level registered on the previous cycle. The mode is picked from three bits: level, both-edges, and polarity.

The raw status vector shows which machines are in `PS_PEND`. The masked vector and the interrupt line are derived from raw status and the enable vector with no extra register.

Top module: `gpio_irq_detect`

## Requirements
- R1: A pin whose direction bit is 1 (output) never moves its raw status bit from 0 to 1, whatever its level or settings.
- R2: In level mode (level bit 1), an input pin whose level equals its polarity bit sets its raw status bit at the next clock edge. Polarity 1 means active high and polarity 0 means active low.
- R3: In edge mode (level bit 0) with the both-edges bit 1, any difference between the pin level and its registered previous level sets the raw status bit at the next clock edge.
- R4: In edge mode with the both-edges bit 0, polarity 1 selects rising edges (previous 0, current 1) and polarity 0 selects falling edges (previous 1, current 0). The other direction has no effect. The previous-level register resets to 0.
- R5: A set raw bit stays set until a cycle with the clear strobe high and a 1 in that bit of the clear pattern. Bits with 0 in the pattern, and all bits when the strobe is low, are left alone.
- R6: When a pin's trigger condition and its clear happen in the same cycle, the bit stays set.
- R7: The masked status equals raw status ANDed with the enable vector. The interrupt line is high exactly when any masked bit is 1. Both follow raw status and enable changes with no added cycle.
- R8: Raw status records events on pins whose enable bit is 0.
- R9: During and right after reset, raw status, masked status and the interrupt line are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Synchronized pin levels |
| cfg_dir | input | 8 | 1 = output pin, never interrupts |
| cfg_level | input | 8 | 1 = level detection, 0 = edge detection |
| cfg_both | input | 8 | Edge mode: 1 = both edges |
| cfg_pol | input | 8 | Rising/high when 1, falling/low when 0 |
| cfg_mask | input | 8 | 1 = pin enabled onto the interrupt line |
| clr_stb | input | 1 | One-cycle clear strobe |
| clr_val | input | 8 | Bits to clear when the strobe is high |
| raw_stat | output | 8 | Sticky per-pin status |
| masked_stat | output | 8 | Raw status ANDed with enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that all inputs are already synchronous to `clk`. They also assume that the configuration vectors sampled at one edge are the ones that decide that edge's update. The stimulus therefore changes pins, settings and the clear strobe only on the falling clock edge, and samples outputs one falling edge later.

Each vector first parks every pin as an output and clears all status, so that the previous-level register holds a known value. It then applies a new configuration together with the new pin levels, so that exactly one registered transition is judged. Every pin carries a different one of the sixteen direction and mode combinations, rotated across four before/after pin patterns that cover all four level transitions.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_PEND = 1'b1
    } pin_state_e;

    typedef enum logic [1:0] {
        DM_FALL  = 2'd0,
        DM_RISE  = 2'd1,
        DM_BOTH  = 2'd2,
        DM_LEVEL = 2'd3
    } detect_mode_e;

    function automatic detect_mode_e pick_mode(input logic lvl, input logic both, input logic pol);
        if (lvl)       return DM_LEVEL;
        else if (both) return DM_BOTH;
        else if (pol)  return DM_RISE;
        else           return DM_FALL;
    endfunction
endpackage

// File: rtl/gpio_irq_sampler.sv
module gpio_irq_sampler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_prev
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev <= '0;
        else        pin_prev <= pin_in;
    end
endmodule

// File: rtl/gpio_irq_qualify.sv
module gpio_irq_qualify
    import gpio_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] pin_now,
    input  logic [W-1:0] pin_prev,
    input  logic [W-1:0] cfg_dir,
    input  logic [W-1:0] cfg_level,
    input  logic [W-1:0] cfg_both,
    input  logic [W-1:0] cfg_pol,
    output logic [W-1:0] trig
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        detect_mode_e mode;
        logic         hit;
        assign mode = pick_mode(cfg_level[i], cfg_both[i], cfg_pol[i]);
        always_comb begin
            unique case (mode)
                DM_LEVEL: hit = (pin_now[i] == cfg_pol[i]);
                DM_BOTH:  hit = pin_now[i] ^ pin_prev[i];
                DM_RISE:  hit = pin_now[i] & ~pin_prev[i];
                DM_FALL:  hit = ~pin_now[i] & pin_prev[i];
                default:  hit = 1'b0;
            endcase
        end
        assign trig[i] = hit & ~cfg_dir[i];
    end
endmodule

// File: rtl/gpio_irq_pin_fsm.sv
module gpio_irq_pin_fsm
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic clr,
    output logic pend
);
    pin_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (trig)         state_d = PS_PEND;
            PS_PEND: if (clr && !trig) state_d = PS_IDLE;
            default:                   state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend = (state_q == PS_PEND);
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] cfg_dir,
    input  logic [W-1:0] cfg_level,
    input  logic [W-1:0] cfg_both,
    input  logic [W-1:0] cfg_pol,
    input  logic [W-1:0] cfg_mask,
    input  logic         clr_stb,
    input  logic [W-1:0] clr_val,
    output logic [W-1:0] raw_stat,
    output logic [W-1:0] masked_stat,
    output logic         irq
);
    logic [W-1:0] pin_prev;
    logic [W-1:0] trig;
    logic [W-1:0] clr_vec;

    assign clr_vec = clr_stb ? clr_val : '0;

    gpio_irq_sampler #(.W(W)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_prev (pin_prev)
    );

    gpio_irq_qualify #(.W(W)) u_qual (
        .pin_now   (pin_in),
        .pin_prev  (pin_prev),
        .cfg_dir   (cfg_dir),
        .cfg_level (cfg_level),
        .cfg_both  (cfg_both),
        .cfg_pol   (cfg_pol),
        .trig      (trig)
    );

    for (genvar i = 0; i < W; i++) begin : g_fsm
        gpio_irq_pin_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .trig  (trig[i]),
            .clr   (clr_vec[i]),
            .pend  (raw_stat[i])
        );
    end

    assign masked_stat = raw_stat & cfg_mask;
    assign irq         = |masked_stat;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] cfg_dir,
    input logic [W-1:0] cfg_level,
    input logic [W-1:0] cfg_pol,
    input logic [W-1:0] cfg_mask,
    input logic         clr_stb,
    input logic [W-1:0] clr_val,
    input logic [W-1:0] raw_stat,
    input logic         irq
);
    logic [W-1:0] clr_eff;
    assign clr_eff = clr_stb ? clr_val : '0;

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_stat & ~$past(raw_stat) & $past(cfg_dir)) == '0)); // R1

    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(~cfg_dir & cfg_level & ~(pin_in ^ cfg_pol)) & ~raw_stat) == '0)); // R2

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw_stat & ~clr_eff) & ~raw_stat) == '0)); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(clr_eff & cfg_level & (cfg_dir | (pin_in ^ cfg_pol))) & raw_stat) == '0)); // R5

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw_stat & cfg_mask) != '0)); // R7
endmodule

bind gpio_irq_detect gpio_irq_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .cfg_dir   (cfg_dir),
    .cfg_level (cfg_level),
    .cfg_pol   (cfg_pol),
    .cfg_mask  (cfg_mask),
    .clr_stb   (clr_stb),
    .clr_val   (clr_val),
    .raw_stat  (raw_stat),
    .irq       (irq)
);

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_in = '0, cfg_dir = '1, cfg_level = '0, cfg_both = '0;
    logic [W-1:0] cfg_pol = '0, cfg_mask = '0, clr_val = '0;
    logic         clr_stb = 1'b0;
    logic [W-1:0] raw_stat, masked_stat;
    logic         irq;
    int           n_vec = 0, n_bad = 0;
    bit           done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_detect #(.W(W)) u0 (.*);

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic [W-1:0] exp_raw, input logic [W-1:0] msk);
        check(req, raw_stat, exp_raw);
        check("R7 masked", masked_stat, exp_raw & msk);
        check("R7 irq", {7'd0, irq}, {7'd0, |(exp_raw & msk)});
    endtask

    logic [W-1:0] pat_a [4] = '{8'hCC, 8'hAA, 8'h00, 8'hFF};
    logic [W-1:0] pat_b [4] = '{8'hAA, 8'hCC, 8'hFF, 8'h00};

    initial begin
        repeat (3) @(negedge clk);
        check_outs("R9 reset", '0, '1);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R9 after reset", '0, '1);

        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [W-1:0] d, l, b, o, m, pv, cu, trig, exp, lvl_hit, cv;
                for (int i = 0; i < W; i++) begin
                    logic [3:0] k;
                    k = 4'((c + i) % 16);
                    d[i] = k[3]; l[i] = k[2]; b[i] = k[1]; o[i] = k[0];
                end
                m  = 8'(c * 37 + p * 11);
                pv = pat_a[p];
                cu = pat_b[p];
                // park all pins as outputs, then clear everything
                cfg_dir = '1; pin_in = pv; cfg_mask = m;
                @(negedge clk);
                clr_stb = 1'b1; clr_val = '1;
                @(negedge clk);
                clr_stb = 1'b0;
                check_outs("R5 full clear", '0, m);
                // apply configuration and new levels together
                cfg_dir = d; cfg_level = l; cfg_both = b; cfg_pol = o; pin_in = cu;
                lvl_hit = ~d & l & ~(cu ^ o);
                trig = lvl_hit | (~d & ~l & (cu ^ pv) & (b | ~(cu ^ o)));
                @(negedge clk);
                exp = trig;
                check_outs("R1 R2 R3 R4 R8 detect", exp, m);
                // same levels, partial clear: level bits win over clear
                cv = 8'h5A ^ 8'(c);
                clr_stb = 1'b1; clr_val = cv;
                @(negedge clk);
                clr_stb = 1'b0;
                exp = (exp & ~cv) | lvl_hit;
                check_outs("R5 R6 partial clear", exp, m);
                // strobe low: pattern ignored
                clr_val = '1;
                @(negedge clk);
                check_outs("R5 strobe low", exp, m);
                // mask change is seen with no added cycle
                cfg_mask = ~m;
                #1;
                check_outs("R7 R8 mask swap", exp, ~m);
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule